// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the status register of a serial non-volatile memory and decides whether writes may proceed. It holds a write-enable latch, a two-bit block-protect field that selects how much of the top of the array is locked, and a protect-enable bit that arms the external write-protect pin. It presents the status byte for the read path. It also gives two answers: whether a pending status write may start its timed write cycle, and whether a data write to a given array address is permitted.

The command decoder upstream pulses the set and clear commands for write enable. It offers the status-write data byte on a valid/ready pair. The byte is taken in a cycle where `sr_wr_valid`, `sr_wr_ready` and `sel` are all high. `sr_wr_ready` is low for as long as a write cycle is busy, and a byte offered then is not taken. The sender may hold or drop it. The taken byte is committed when `sel` falls. At that point `sr_wr_start` pulses for one cycle, and the external write-cycle timer drives `busy` in response. The protect bits live in flip-flops with parameterised reset values, which stand in for their non-volatile state.

Top module: `sp_status_guard`

## Requirements
- R1: When `busy` is low, `status_byte` bit 7 is the protect-enable bit, bits 6..4 are 0, bits 3..2 are the block-protect field (bit 3 high half), bit 1 is the write-enable latch and bit 0 is 0.
- R2: While `busy` is high, `status_byte` reads 8'hFF and `sr_wr_ready` is low, and a status byte offered during that time is never committed.
- R3: The write-enable latch resets to 0. A `cmd_wen_set` pulse sets it and a `cmd_wen_clr` pulse clears it whatever `wp_n` is. When both pulse in the same cycle, clear wins.
- R4: The write-enable latch clears in the cycle after `busy` falls.
- R5: Block-protect field 00 locks nothing, 01 locks addresses whose two top bits are 11, 10 locks addresses whose top bit is 1, and 11 locks the whole array.
- R6: `arr_wr_ok` is high exactly when write enable is 1, `busy` is low and the address is not locked; `wp_n` and the protect-enable bit do not affect it.
- R7: A taken status byte commits on the falling edge of `sel` only if write enable is 1. The commit raises `sr_wr_start` for one cycle and loads only data bits 7, 3 and 2 into the register.
- R8: Hardware protection is active while `wp_n` is 0 and protect-enable is 1. It blocks any status commit, and if it is active for any cycle between taking the byte and deselect, that write is dropped. With protect-enable 0, `wp_n` has no effect.
- R9: While hardware protection is active, protect-enable stays 1.
- R10: After reset, protect-enable and the block-protect field take the values of the parameters `RST_WPEN` and `RST_BP`, which default to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Device selected (high during a serial transaction) |
| busy | input | 1 | Internal write cycle in progress |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wen_set | input | 1 | Decoded set-write-enable command pulse |
| cmd_wen_clr | input | 1 | Decoded clear-write-enable command pulse |
| sr_wr_valid | input | 1 | Status-write data byte valid |
| sr_wr_ready | output | 1 | Status-write data byte can be taken |
| sr_wr_data | input | 8 | Status-write data byte |
| arr_addr | input | ADDR_W | Target address of a data write |
| status_byte | output | 8 | Status byte for the read path |
| sr_wr_start | output | 1 | One-cycle pulse: status write begins its timed cycle |
| arr_wr_ok | output | 1 | Data write to `arr_addr` is permitted |

## Verification
The hardest case to reach is a status write that is dropped because protection became active for a single cycle in mid-transaction and then went away before deselect. At deselect, every input that a commit depends on looks permissive again. The stimulus first sets protect-enable with `wp_n` high. It then has a byte taken, lowers `wp_n` for one cycle, raises it, and deselects, and expects no start pulse and an unchanged register. A related case offers a byte while `busy` is high, lets `busy` fall and sets write enable again before deselect, so that only the refused handshake keeps the commit away.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Bit positions of the status byte seen by the read path
  localparam int unsigned SB_WPEN = 7;
  localparam int unsigned SB_BPH  = 3;
  localparam int unsigned SB_BPL  = 2;
  localparam int unsigned SB_WEN  = 1;
  localparam int unsigned SB_BUSY = 0;

  // Field values that model non-volatile bits
  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } sp_nv_t;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } sp_lock_e;

  function automatic logic [7:0] sp_pack_status(input sp_nv_t nv, input logic wen);
    logic [7:0] s;
    s = '0;
    s[SB_WPEN] = nv.wpen;
    s[SB_BPH]  = nv.bp[1];
    s[SB_BPL]  = nv.bp[0];
    s[SB_WEN]  = wen;
    return s;
  endfunction

  function automatic sp_nv_t sp_unpack_nv(input logic [7:0] d);
    sp_nv_t nv;
    nv.wpen = d[SB_WPEN];
    nv.bp   = {d[SB_BPH], d[SB_BPL]};
    return nv;
  endfunction
endpackage

// File: rtl/sp_wen_latch.sv
module sp_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic wen
);
  logic busy_q;
  logic busy_end;

  assign busy_end = busy_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wen    <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy_end) begin
        wen <= 1'b0;
      end else if (!busy) begin
        if (clr_cmd) begin
          wen <= 1'b0;
        end else if (set_cmd) begin
          wen <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sp_prot_map.sv
module sp_prot_map
  import sp_pkg::*;
(
  input  logic [1:0] bp,
  input  logic [1:0] addr_top,
  output logic       locked
);
  sp_lock_e lvl;
  assign lvl = sp_lock_e'(bp);

  always_comb begin
    unique case (lvl)
      LOCK_NONE:    locked = 1'b0;
      LOCK_QUARTER: locked = &addr_top;
      LOCK_HALF:    locked = addr_top[1];
      LOCK_ALL:     locked = 1'b1;
      default:      locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/sp_sr_stage.sv
module sp_sr_stage
  import sp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       busy,
  input  logic       wen,
  input  logic       hw_prot,
  input  logic       take,
  input  logic [7:0] data,
  output logic       commit,
  output sp_nv_t     commit_nv
);
  logic   sel_q;
  logic   pend;
  sp_nv_t pend_nv;
  logic   deselect;
  logic   unused_bits;

  assign unused_bits = ^{data[6:4], data[1:0]};
  assign deselect    = sel_q && !sel;
  assign commit      = deselect && pend && wen && !busy && !hw_prot;
  assign commit_nv   = pend_nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      pend    <= 1'b0;
      pend_nv <= '0;
    end else begin
      sel_q <= sel;
      if (!sel || hw_prot) begin
        pend <= 1'b0;
      end else if (take) begin
        pend    <= 1'b1;
        pend_nv <= sp_unpack_nv(data);
      end
    end
  end
endmodule

// File: rtl/sp_status_guard.sv
module sp_status_guard
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter logic [1:0]  RST_BP   = 2'b00,
  parameter logic        RST_WPEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              busy,
  input  logic              wp_n,
  input  logic              cmd_wen_set,
  input  logic              cmd_wen_clr,
  input  logic              sr_wr_valid,
  output logic              sr_wr_ready,
  input  logic [7:0]        sr_wr_data,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        status_byte,
  output logic              sr_wr_start,
  output logic              arr_wr_ok
);
  localparam int unsigned TOP  = ADDR_W - 1;
  localparam int unsigned LOWW = ADDR_W - 2;

  sp_nv_t nv_q;
  sp_nv_t nv_new;
  logic   wen;
  logic   hw_prot;
  logic   take;
  logic   commit;
  logic   locked;
  logic   unused_addr;

  assign unused_addr = ^arr_addr[LOWW-1:0];
  assign hw_prot     = !wp_n && nv_q.wpen;
  assign sr_wr_ready = !busy;
  assign take        = sr_wr_valid && sr_wr_ready && sel;

  sp_wen_latch wen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .set_cmd (cmd_wen_set),
    .clr_cmd (cmd_wen_clr),
    .wen     (wen)
  );

  sp_sr_stage stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .busy      (busy),
    .wen       (wen),
    .hw_prot   (hw_prot),
    .take      (take),
    .data      (sr_wr_data),
    .commit    (commit),
    .commit_nv (nv_new)
  );

  sp_prot_map map_i (
    .bp       (nv_q.bp),
    .addr_top (arr_addr[TOP -: 2]),
    .locked   (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q.wpen   <= RST_WPEN;
      nv_q.bp     <= RST_BP;
      sr_wr_start <= 1'b0;
    end else begin
      sr_wr_start <= commit;
      if (commit) begin
        nv_q <= nv_new;
      end
    end
  end

  assign status_byte = busy ? 8'hFF : sp_pack_status(nv_q, wen);
  assign arr_wr_ok   = wen && !busy && !locked;
endmodule

// File: rtl/sp_status_guard_chk.sv
module sp_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wp_n,
  input logic       sr_wr_ready,
  input logic [7:0] status_byte,
  input logic       sr_wr_start,
  input logic       arr_wr_ok
);
  p_idle_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_byte[6:4] == 3'b000 && !status_byte[0]));

  p_busy_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status_byte == 8'hFF && !sr_wr_ready));

  p_wen_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> (busy || !status_byte[1]));

  p_full_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status_byte[3:2] == 2'b11) |-> !arr_wr_ok);

  p_start_needs_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_start |-> $past(status_byte[1]));

  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_wr_start && !busy && !$past(busy)) |-> $stable(status_byte[7:2]));

  p_hw_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !busy && status_byte[7]) |=> !sr_wr_start);

  p_wpen_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !busy && status_byte[7]) |=> status_byte[7]);
endmodule

bind sp_status_guard sp_status_guard_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .wp_n        (wp_n),
  .sr_wr_ready (sr_wr_ready),
  .status_byte (status_byte),
  .sr_wr_start (sr_wr_start),
  .arr_wr_ok   (arr_wr_ok)
);

// File: tb/sp_status_guard_tb_top.sv
module sp_status_guard_tb_top;
  localparam int unsigned AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          busy = 1'b0;
  logic          wp_n = 1'b1;
  logic          cmd_wen_set = 1'b0;
  logic          cmd_wen_clr = 1'b0;
  logic          sr_wr_valid = 1'b0;
  logic          sr_wr_ready;
  logic [7:0]    sr_wr_data = '0;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0]    status_byte;
  logic          sr_wr_start;
  logic          arr_wr_ok;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sp_status_guard #(.ADDR_W(AW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .busy        (busy),
    .wp_n        (wp_n),
    .cmd_wen_set (cmd_wen_set),
    .cmd_wen_clr (cmd_wen_clr),
    .sr_wr_valid (sr_wr_valid),
    .sr_wr_ready (sr_wr_ready),
    .sr_wr_data  (sr_wr_data),
    .arr_addr    (arr_addr),
    .status_byte (status_byte),
    .sr_wr_start (sr_wr_start),
    .arr_wr_ok   (arr_wr_ok)
  );

  // {block-protect, address, expected permission}, write enable held at 1
  localparam logic [16:0] VEC [12] = '{
    {2'b00, 14'h0000, 1'b1}, {2'b00, 14'h3FFF, 1'b1},
    {2'b01, 14'h2FFF, 1'b1}, {2'b01, 14'h3000, 1'b0},
    {2'b01, 14'h3FFF, 1'b0}, {2'b01, 14'h0000, 1'b1},
    {2'b10, 14'h1FFF, 1'b1}, {2'b10, 14'h2000, 1'b0},
    {2'b10, 14'h3000, 1'b0}, {2'b11, 14'h0000, 1'b0},
    {2'b11, 14'h1FFF, 1'b0}, {2'b11, 14'h3FFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic s, input logic c);
    @(negedge clk);
    cmd_wen_set = s;
    cmd_wen_clr = c;
    @(negedge clk);
    cmd_wen_set = 1'b0;
    cmd_wen_clr = 1'b0;
  endtask

  task automatic wr_sr(input logic [7:0] d, output logic got);
    @(negedge clk) sel = 1'b1;
    @(negedge clk);
    sr_wr_valid = 1'b1;
    sr_wr_data  = d;
    @(negedge clk) sr_wr_valid = 1'b0;
    @(negedge clk) sel = 1'b0;
    @(negedge clk) got = sr_wr_start;
    @(negedge clk);
  endtask

  initial begin
    #4ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic got;
    logic [1:0] cur_bp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 R10 reset status", status_byte, 8'h00);
    chk("R2 ready idle", {7'b0, sr_wr_ready}, 8'h01);
    chk("R6 no wen no write", {7'b0, arr_wr_ok}, 8'h00);

    pulse_cmd(1'b1, 1'b0);
    chk("R3 set wen", status_byte, 8'h02);
    pulse_cmd(1'b1, 1'b1);
    chk("R3 clear wins", status_byte, 8'h00);

    wr_sr(8'hFF, got);
    chk("R7 no start without wen", {7'b0, got}, 8'h00);
    chk("R7 unchanged without wen", status_byte, 8'h00);

    pulse_cmd(1'b1, 1'b0);
    wr_sr(8'hFF, got);
    chk("R7 start pulse", {7'b0, got}, 8'h01);
    chk("R1 R7 only fields loaded", status_byte, 8'h8E);

    @(negedge clk) busy = 1'b1;
    @(negedge clk);
    chk("R2 busy ones", status_byte, 8'hFF);
    chk("R2 busy not ready", {7'b0, sr_wr_ready}, 8'h00);
    chk("R6 busy no array write", {7'b0, arr_wr_ok}, 8'h00);
    busy = 1'b0;
    @(negedge clk);
    chk("R4 wen cleared at end", status_byte, 8'h8C);

    // hardware protection active
    wp_n = 1'b0;
    pulse_cmd(1'b1, 1'b0);
    wr_sr(8'h00, got);
    chk("R8 hw lock no start", {7'b0, got}, 8'h00);
    chk("R9 wpen kept", status_byte, 8'h8E);
    pulse_cmd(1'b0, 1'b1);
    chk("R3 clear with wp low", status_byte, 8'h8C);

    wp_n = 1'b1;
    pulse_cmd(1'b1, 1'b0);
    wr_sr(8'h80, got);
    chk("R8 wp high allows", status_byte, 8'h82);

    // one-cycle protection between take and deselect
    @(negedge clk) sel = 1'b1;
    @(negedge clk);
    sr_wr_valid = 1'b1;
    sr_wr_data  = 8'h00;
    @(negedge clk);
    sr_wr_valid = 1'b0;
    wp_n = 1'b0;
    @(negedge clk) wp_n = 1'b1;
    @(negedge clk) sel = 1'b0;
    @(negedge clk) got = sr_wr_start;
    chk("R8 mid abort no start", {7'b0, got}, 8'h00);
    chk("R8 mid abort unchanged", status_byte, 8'h82);

    // byte offered while busy is refused
    @(negedge clk);
    busy = 1'b1;
    sel = 1'b1;
    @(negedge clk);
    sr_wr_valid = 1'b1;
    sr_wr_data  = 8'h00;
    @(negedge clk);
    sr_wr_valid = 1'b0;
    busy = 1'b0;
    pulse_cmd(1'b1, 1'b0);
    sel = 1'b0;
    @(negedge clk) got = sr_wr_start;
    chk("R2 refused byte no start", {7'b0, got}, 8'h00);
    chk("R2 refused byte unchanged", status_byte, 8'h82);

    wr_sr(8'h00, got);
    chk("R8 clear wpen", status_byte, 8'h02);
    wp_n = 1'b0;
    wr_sr(8'h0C, got);
    chk("R8 wp ignored wpen 0", status_byte, 8'h0E);

    wp_n = 1'b1;
    cur_bp = 2'b11;
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][16:15] != cur_bp) begin
        wr_sr({4'h0, VEC[i][16:15], 2'b00}, got);
        cur_bp = VEC[i][16:15];
      end
      @(negedge clk) arr_addr = VEC[i][14:1];
      #1;
      chk($sformatf("R5 R6 map bp=%b addr=%h", cur_bp, arr_addr),
          {7'b0, arr_wr_ok}, {7'b0, VEC[i][0]});
    end

    wr_sr(8'h80, got);
    wp_n = 1'b0;
    @(negedge clk) arr_addr = 14'h3FFF;
    #1;
    chk("R6 hw lock leaves array", {7'b0, arr_wr_ok}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule